// File: doc/BRIEF.md
# Enhanced Physical Memory Protection Permission Checker

This block decides whether one memory access may proceed under physical memory protection. Each request carries the privilege level of the hart (machine or a lower level), the set of rights it needs (read, write, execute) and one hit flag per protection entry from an address comparator outside the block. The block also receives each entry's configuration byte and two security control bits. The first bit, `secMml`, locks machine mode down. The second, `secMmwp`, makes the default policy deny-all.

The block picks the entry that governs the access and works out the set of rights that entry grants. If the security bits call for it, the grant comes from one of two 16-row lookup tables, one for machine mode and one for lower modes, in place of the plain permission mask. When no entry hits, a default policy applies. The block registers the verdict and the granted set and presents them one clock after the request. Address comparison, trap raising and storage of the configuration are done elsewhere.

Configuration byte layout, per entry: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 address-match mode (00 means the entry is off), bit 7 lock. Entry `i` sits at bits `[8*i+7 : 8*i]` of `entryCfg`. Privilege vectors (`reqPriv`, `rspGrant`) use bit 0 for read, bit 1 for write and bit 2 for execute.

Top module: `pmpchk_top`

## Requirements
- R1: `rspValid` is the value of `reqValid` delayed by one clock. While reset is held, `rspValid`, `rspAllow` and `rspGrant` are all 0.
- R2: An entry whose address-match mode field (bits 4:3) is 00 never governs an access, even when its hit flag is set.
- R3: Among the entries that hit and are not off, the one with the lowest index governs. Higher-indexed hits are ignored.
- R4: With `secMml` clear and an entry governing, machine mode is granted read, write and execute if the entry's lock bit is 0. In every other case the grant equals the entry's bits 2:0.
- R5: With `secMml` set, a governing entry and machine mode, the table index is {lock, read, write, execute} (lock in index bit 3). Indices 0, 1, 4, 5, 6, 7 and 8 grant nothing. Indices 2, 3 and 14 grant read and write. Indices 9 and 10 grant execute. Indices 11 and 13 grant read and execute. Indices 12 and 15 grant read.
- R6: With `secMml` set, a governing entry and a lower mode, using the same index: indices 0, 8, 9, 12, 13 and 14 grant nothing. Indices 1, 10 and 11 grant execute. Indices 2, 4 and 15 grant read. Indices 3 and 6 grant read and write. Index 5 grants read and execute. Index 7 grants all three.
- R7: With no governing entry and `secMmwp` set, the grant is empty for every mode, machine mode included.
- R8: With no governing entry, `secMmwp` clear and `secMml` set, machine mode is granted read and write (grant 3'b011). Lower modes get an empty grant.
- R9: With no governing entry and both security bits clear, machine mode is granted all three rights and lower modes get an empty grant.
- R10: `rspAllow` is 1 exactly when every bit set in the request's `reqPriv` is also set in `rspGrant`. An empty request is therefore allowed.
- R11: In a cycle after a clock with no request, `rspAllow` and `rspGrant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqMachine | input | 1 | 1 = machine mode, 0 = lower mode |
| reqPriv | input | 3 | Requested rights {execute, write, read} |
| entryHit | input | NUM_ENTRIES | Per-entry address hit from the comparator |
| entryCfg | input | 8*NUM_ENTRIES | Per-entry configuration bytes |
| secMml | input | 1 | Machine-mode lockdown enable |
| secMmwp | input | 1 | Deny-by-default policy enable |
| rspValid | output | 1 | Response present |
| rspAllow | output | 1 | Access permitted |
| rspGrant | output | 3 | Granted rights {execute, write, read} |

## Verification
On every cycle, the checker confirms four things: the one-cycle response timing, the subset rule that links the verdict to the grant, the zeroed outputs after idle cycles, and the default policies whenever no live entry hits. It also covers the legacy machine-mode grant from an unlocked entry 0. Only the bench scenarios show the parts that depend on picking a specific entry and reading a table. These are the lowest-index priority among several hits, off entries being skipped, and every row of both lockdown tables, which the bench sweeps in full for every request pattern.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;
  localparam int CFG_W   = 8;
  localparam int BIT_RD  = 0;
  localparam int BIT_WR  = 1;
  localparam int BIT_EX  = 2;
  localparam int AM_LO   = 3;
  localparam int BIT_LK  = 7;
  localparam int IDX_MAX_W = 6;

  // bit0 read, bit1 write, bit2 execute
  typedef logic [2:0] priv_t;
  localparam priv_t PRIV_NONE = 3'b000;
  localparam priv_t PRIV_R    = 3'b001;
  localparam priv_t PRIV_RW   = 3'b011;
  localparam priv_t PRIV_X    = 3'b100;
  localparam priv_t PRIV_RX   = 3'b101;
  localparam priv_t PRIV_ALL  = 3'b111;

  typedef struct packed {
    logic                 capture;
    logic                 found;
    logic                 machine;
    logic                 lockdown;
    logic                 denyDefault;
    logic [IDX_MAX_W-1:0] idx;
  } ctrl_t;
endpackage

// File: rtl/pmpchk_ctrl.sv
module pmpchk_ctrl
  import pmpchk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                         reqValid,
  input  logic                         reqMachine,
  input  logic                         secMml,
  input  logic                         secMmwp,
  input  logic [NUM_ENTRIES-1:0]       entryHit,
  input  logic [NUM_ENTRIES*CFG_W-1:0] entryCfg,
  output ctrl_t                        ctrlOut
);
  logic [NUM_ENTRIES-1:0] liveHit;
  logic                   anyLive;
  logic [IDX_MAX_W-1:0]   firstIdx;

  // an entry with match mode 00 is off and never counts
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_live
    assign liveHit[g] = entryHit[g] && (entryCfg[g*CFG_W+AM_LO +: 2] != 2'b00);
  end

  // scan downward so the lowest index is written last and wins
  always_comb begin
    anyLive  = 1'b0;
    firstIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (liveHit[i]) begin
        anyLive  = 1'b1;
        firstIdx = IDX_MAX_W'(i);
      end
    end
  end

  always_comb begin
    ctrlOut.capture     = reqValid;
    ctrlOut.found       = anyLive;
    ctrlOut.machine     = reqMachine;
    ctrlOut.lockdown    = secMml;
    ctrlOut.denyDefault = secMmwp;
    ctrlOut.idx         = firstIdx;
  end
endmodule

// File: rtl/pmpchk_dpath.sv
module pmpchk_dpath
  import pmpchk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctrl_t                        ctrlIn,
  input  priv_t                        reqPriv,
  input  logic [NUM_ENTRIES*CFG_W-1:0] entryCfg,
  output logic                         rspValid,
  output logic                         rspAllow,
  output priv_t                        rspGrant
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [CFG_W-1:0] cfgArr [NUM_ENTRIES];
  logic [CFG_W-1:0] selCfg;
  logic [3:0]       lookIdx;
  priv_t            tblMachine;
  priv_t            tblLower;
  priv_t            grantNext;
  logic             allowNext;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_unpack
    assign cfgArr[g] = entryCfg[g*CFG_W +: CFG_W];
  end

  assign selCfg  = cfgArr[ctrlIn.idx[IDX_W-1:0]];
  assign lookIdx = {selCfg[BIT_LK], selCfg[BIT_RD], selCfg[BIT_WR], selCfg[BIT_EX]};

  always_comb begin
    unique case (lookIdx)
      4'd2, 4'd3, 4'd14: tblMachine = PRIV_RW;
      4'd9, 4'd10:       tblMachine = PRIV_X;
      4'd11, 4'd13:      tblMachine = PRIV_RX;
      4'd12, 4'd15:      tblMachine = PRIV_R;
      default:           tblMachine = PRIV_NONE;
    endcase
  end

  always_comb begin
    unique case (lookIdx)
      4'd1, 4'd10, 4'd11: tblLower = PRIV_X;
      4'd2, 4'd4, 4'd15:  tblLower = PRIV_R;
      4'd3, 4'd6:         tblLower = PRIV_RW;
      4'd5:               tblLower = PRIV_RX;
      4'd7:               tblLower = PRIV_ALL;
      default:            tblLower = PRIV_NONE;
    endcase
  end

  always_comb begin
    if (!ctrlIn.found) begin
      if (ctrlIn.denyDefault)   grantNext = PRIV_NONE;
      else if (ctrlIn.lockdown) grantNext = ctrlIn.machine ? PRIV_RW : PRIV_NONE;
      else                      grantNext = ctrlIn.machine ? PRIV_ALL : PRIV_NONE;
    end else if (ctrlIn.lockdown) begin
      grantNext = ctrlIn.machine ? tblMachine : tblLower;
    end else if (ctrlIn.machine && !selCfg[BIT_LK]) begin
      grantNext = PRIV_ALL;
    end else begin
      grantNext = selCfg[2:0];
    end
  end

  assign allowNext = ((reqPriv & ~grantNext) == PRIV_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspAllow <= 1'b0;
      rspGrant <= PRIV_NONE;
    end else begin
      rspValid <= ctrlIn.capture;
      rspAllow <= ctrlIn.capture && allowNext;
      rspGrant <= ctrlIn.capture ? grantNext : PRIV_NONE;
    end
  end
endmodule

// File: rtl/pmpchk_top.sv
module pmpchk_top
  import pmpchk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reqValid,
  input  logic                         reqMachine,
  input  logic [2:0]                   reqPriv,
  input  logic [NUM_ENTRIES-1:0]       entryHit,
  input  logic [NUM_ENTRIES*CFG_W-1:0] entryCfg,
  input  logic                         secMml,
  input  logic                         secMmwp,
  output logic                         rspValid,
  output logic                         rspAllow,
  output logic [2:0]                   rspGrant
);
  ctrl_t ctrlBus;

  pmpchk_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) ctrl_i (
    .reqValid  (reqValid),
    .reqMachine(reqMachine),
    .secMml    (secMml),
    .secMmwp   (secMmwp),
    .entryHit  (entryHit),
    .entryCfg  (entryCfg),
    .ctrlOut   (ctrlBus)
  );

  pmpchk_dpath #(.NUM_ENTRIES(NUM_ENTRIES)) dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrlIn  (ctrlBus),
    .reqPriv (reqPriv),
    .entryCfg(entryCfg),
    .rspValid(rspValid),
    .rspAllow(rspAllow),
    .rspGrant(rspGrant)
  );
endmodule

// File: rtl/pmpchk_checker.sv
module pmpchk_checker
  import pmpchk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reqValid,
  input logic                         reqMachine,
  input logic [2:0]                   reqPriv,
  input logic [NUM_ENTRIES-1:0]       entryHit,
  input logic [NUM_ENTRIES*CFG_W-1:0] entryCfg,
  input logic                         secMml,
  input logic                         secMmwp,
  input logic                         rspValid,
  input logic                         rspAllow,
  input logic [2:0]                   rspGrant
);
  logic [NUM_ENTRIES-1:0] onHit;
  logic                   noneLive;
  logic [2:0]             lastPriv;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_on
    assign onHit[g] = entryHit[g] && (entryCfg[g*CFG_W+AM_LO +: 2] != 2'b00);
  end
  assign noneLive = (onHit == '0);

  always_ff @(posedge clk) lastPriv <= reqPriv;

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  p_subset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> (rspAllow == ((lastPriv & ~rspGrant) == 3'b000)));
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> (!rspAllow && rspGrant == 3'b000));
  p_deny_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && noneLive && secMmwp) |=> (rspGrant == 3'b000));
  p_lockdown_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && noneLive && !secMmwp && secMml) |=>
      (rspGrant == ($past(reqMachine) ? 3'b011 : 3'b000)));
  p_open_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && noneLive && !secMmwp && !secMml) |=>
      (rspGrant == ($past(reqMachine) ? 3'b111 : 3'b000)));
  p_legacy_machine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !secMml && reqMachine && onHit[0] && !entryCfg[BIT_LK]) |=>
      (rspGrant == 3'b111));
endmodule

bind pmpchk_top pmpchk_checker #(.NUM_ENTRIES(NUM_ENTRIES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqMachine(reqMachine),
  .reqPriv   (reqPriv),
  .entryHit  (entryHit),
  .entryCfg  (entryCfg),
  .secMml    (secMml),
  .secMmwp   (secMmwp),
  .rspValid  (rspValid),
  .rspAllow  (rspAllow),
  .rspGrant  (rspGrant)
);

// File: tb/pmpchk_top_tb_top.sv
module pmpchk_top_tb_top;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reqValid, reqMachine, secMml, secMmwp;
  logic [2:0]    reqPriv;
  logic [NE-1:0] entryHit;
  logic [NE*8-1:0] entryCfg;
  logic          rspValid, rspAllow;
  logic [2:0]    rspGrant;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  // {execute, write, read} grants per {lock, read, write, execute} index
  int tblM [16] = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
  int tblU [16] = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};

  always #5 clk = ~clk;

  pmpchk_top #(.NUM_ENTRIES(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqMachine(reqMachine),
    .reqPriv(reqPriv), .entryHit(entryHit), .entryCfg(entryCfg),
    .secMml(secMml), .secMmwp(secMmwp), .rspValid(rspValid),
    .rspAllow(rspAllow), .rspGrant(rspGrant)
  );

  function automatic logic [7:0] mkCfg(input bit lk, input bit [1:0] am, input bit [2:0] xwr);
    return {lk, 2'b00, am, xwr};
  endfunction

  function automatic logic [2:0] refGrant(input bit m, input logic [NE-1:0] hits,
                                          input logic [NE*8-1:0] cfg, input bit mml, input bit mmwp);
    int sel = -1;
    logic [7:0] c;
    for (int i = 0; i < NE; i++)
      if (sel < 0 && hits[i] && cfg[i*8+3 +: 2] != 2'b00) sel = i;
    if (sel < 0) begin
      if (mmwp) return 3'd0;
      if (mml) return m ? 3'd3 : 3'd0;
      return m ? 3'd7 : 3'd0;
    end
    c = cfg[sel*8 +: 8];
    if (!mml) return (m && !c[7]) ? 3'd7 : c[2:0];
    return m ? 3'(tblM[{c[7], c[0], c[1], c[2]}]) : 3'(tblU[{c[7], c[0], c[1], c[2]}]);
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual valid/allow/grant=%b expected=%b", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives one request and checks its response
  task automatic apply(input string tag, input bit v, input bit m, input bit [2:0] p,
                       input logic [NE-1:0] h, input logic [NE*8-1:0] c, input bit mml, input bit mmwp);
    logic [2:0] g;
    logic [4:0] exp;
    reqValid = v; reqMachine = m; reqPriv = p; entryHit = h; entryCfg = c;
    secMml = mml; secMmwp = mmwp;
    g = refGrant(m, h, c, mml, mmwp);
    exp = v ? {1'b1, ((p & ~g) == 3'b000), g} : 5'b0;
    @(negedge clk);
    check(tag, {rspValid, rspAllow, rspGrant}, exp);
  endtask

  initial begin
    #1500000;
    nErrors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [NE*8-1:0] cfg;
    rst_n = 0; reqValid = 1; reqMachine = 1; reqPriv = 7; entryHit = '1;
    entryCfg = '1; secMml = 0; secMmwp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {rspValid, rspAllow, rspGrant}, 5'b0);
    rst_n = 1;

    // R11 idle
    apply("R11 idle", 0, 1, 3'b111, '1, '1, 0, 0);
    apply("R1 single request", 1, 0, 3'b001, 8'h01, {56'h0, mkCfg(0, 2'b01, 3'b001)}, 0, 0);
    apply("R11 idle after request", 0, 0, 3'b001, 8'h01, {56'h0, mkCfg(0, 2'b01, 3'b001)}, 0, 0);

    // R2: off entry with all rights hits, lower mode gets default deny
    apply("R2 off entry ignored", 1, 0, 3'b001, 8'h01, {56'h0, mkCfg(0, 2'b00, 3'b111)}, 0, 0);
    cfg = '0; cfg[7:0] = mkCfg(0, 2'b00, 3'b111); cfg[31:24] = mkCfg(0, 2'b11, 3'b100);
    apply("R2 off entry skipped to next", 1, 0, 3'b100, 8'h09, cfg, 0, 0);
    apply("R2 off entry skipped read denied", 1, 0, 3'b001, 8'h09, cfg, 0, 0);

    // R3 priority
    cfg = '0; cfg[23:16] = mkCfg(0, 2'b01, 3'b001); cfg[47:40] = mkCfg(0, 2'b01, 3'b011);
    apply("R3 lowest index wins", 1, 0, 3'b011, 8'h24, cfg, 0, 0);
    apply("R3 higher only", 1, 0, 3'b011, 8'h20, cfg, 0, 0);

    // R4 legacy
    apply("R4 machine unlocked", 1, 1, 3'b111, 8'h01, {56'h0, mkCfg(0, 2'b01, 3'b000)}, 0, 0);
    apply("R4 machine locked", 1, 1, 3'b010, 8'h01, {56'h0, mkCfg(1, 2'b01, 3'b001)}, 0, 0);
    apply("R4 lower mode mask", 1, 0, 3'b101, 8'h01, {56'h0, mkCfg(0, 2'b10, 3'b101)}, 0, 0);

    // R5, R6 full table sweep
    for (int k = 0; k < 16; k++)
      for (int md = 0; md < 2; md++)
        for (int p = 0; p < 8; p++) begin
          logic [3:0] kk;
          kk = 4'(k);
          cfg = '0;
          cfg[15:8] = mkCfg(kk[3], 2'b01, {kk[0], kk[1], kk[2]});
          apply(md ? "R5 machine lockdown table" : "R6 lower lockdown table",
                1, md[0], 3'(p), 8'h02, cfg, 1, 0);
        end

    // R7, R8, R9 defaults
    for (int md = 0; md < 2; md++)
      for (int p = 0; p < 8; p++) begin
        apply("R7 deny default", 1, md[0], 3'(p), 8'h00, '0, 0, 1);
        apply("R7 deny default with lockdown", 1, md[0], 3'(p), 8'h00, '0, 1, 1);
        apply("R8 lockdown default", 1, md[0], 3'(p), 8'h00, '0, 1, 0);
        apply("R9 open default", 1, md[0], 3'(p), 8'h00, '0, 0, 0);
      end

    // R10 random mix
    for (int n = 0; n < 3000; n++) begin
      logic [NE*8-1:0] rc;
      for (int e = 0; e < NE; e++) rc[e*8 +: 8] = 8'($urandom);
      apply("R10 random access", ($urandom % 8) != 0, 1'($urandom), 3'($urandom),
            NE'($urandom), rc, 1'($urandom), (($urandom % 4) == 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule